// File: doc/BRIEF.md
# MMIO Address Decoder with Global Register File

This block sits behind the host link and turns each memory-mapped request into either a global register access or a per-process action access. It sees a 32-bit offset. When the top bit is clear, the request lands in a 2 GB global window of 64-bit registers, and this block answers it from its own small register file. When the top bit is set, the request belongs to the per-process space. That space is cut into 4 MB slices, and the slice number travels with the request as a process ID tag. The 32-bit register request and its tag are forwarded to the action logic, and the 32-bit answer comes back from it.

The global register file holds five read-only words fixed at build time: release version, build date, card capability, user code and reconfiguration code. It also holds a command word, a status word and a 64-bit up-time counter. Writing the command word with bit 0 set issues a one-cycle soft reset to the downstream data mover and action logic.

Every request is answered exactly one cycle later. A small response state machine tracks the answer. Its states are `ST_IDLE` (no response due), `ST_GLB_RSP` (global answer on the bus) and `ST_ACT_RSP` (action answer on the bus). Each accepted request moves the machine into the answer state that matches its space, from any state. A cycle with no request moves it back to `ST_IDLE`. Back-to-back requests therefore chain answer states cycle after cycle.

Top module: `mmio_space_decoder`

## Requirements
- R1: A request whose address bit 31 is 1 is an action access. Its process ID is address bits [30:22] (9 bits, 512 processes) and its register offset is bits [21:0]. These appear on `act_pasid` and `act_offset` one cycle after the request. A request whose bit 31 is 0 is a global access.
- R2: Every cycle with `req_valid` high is followed by exactly one cycle with `rsp_valid` high. A cycle without a request is followed by `rsp_valid` low.
- R3: An action request raises `act_valid` for one cycle, one cycle after the request. In that cycle it carries the write flag and `req_wdata[31:0]`. A read response returns `{32'h0, act_rdata}` in that same cycle, and a write response returns 0. A global request never raises `act_valid`.
- R4: Global reads at byte offsets 0x00, 0x08, 0x30, 0x50 and 0x60 return the version, build-date, capability, user-code and reconfiguration-code parameters respectively.
- R5: A global write to offset 0x10 with data bit 0 set drives `soft_rst` high for exactly the response cycle. With bit 0 clear there is no pulse. A read of 0x10 returns 0.
- R6: A read of offset 0x18 returns, as sampled in the request cycle: bit 3 = OR of all `fault_bits`, bit 2 = `axi_busy`, bit 1 = `tlx_busy`, bit 0 = `buf_empty`, and all other bits 0.
- R7: A read of offset 0x40 returns a 64-bit counter that advances by one on every clock after reset. Two reads whose request cycles are N clocks apart differ by N.
- R8: A global read at any other offset, or at an offset with address bits [2:0] non-zero, returns 0. Global writes to any offset other than the command word change nothing visible: there is no pulse, no forwarding, and later reads are unchanged. Responses to global writes carry 0.
- R9: While reset is asserted, `rsp_valid`, `act_valid` and `soft_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Offset within the device window |
| req_wdata | input | 64 | Write data (action uses [31:0]) |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Response data |
| act_valid | output | 1 | Forwarded action request |
| act_write | output | 1 | Forwarded write flag |
| act_pasid | output | 9 | Process ID tag |
| act_offset | output | 22 | Register offset within the action |
| act_wdata | output | 32 | Forwarded write data |
| act_rdata | input | 32 | Action read data during the forwarded cycle |
| fault_bits | input | 8 | Fault-isolation flags |
| axi_busy | input | 1 | AXI side busy |
| tlx_busy | input | 1 | Link side busy |
| buf_empty | input | 1 | Internal data buffers empty |
| soft_rst | output | 1 | One-cycle soft reset to data mover and action |

## Verification
Two things can land in the same cycle: the soft-reset pulse from a command write, and the forwarding of an action request that arrives right behind it. The bench issues a command write and, in the very next cycle, an action read. It checks that the pulse is high exactly while the command answer is out and that no forwarding happens then. In the following cycle it checks that the pulse has dropped and that the action request appears with its tag and answer data. The up-time counter is likewise read at spacings of 2 to 7 cycles, to show that reading it never disturbs its counting.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GLB_RSP = 2'd1,
        ST_ACT_RSP = 2'd2
    } rsp_state_e;

    // 8-byte word indices inside the global window
    localparam int unsigned W_VERSION = 0;
    localparam int unsigned W_BUILD   = 1;
    localparam int unsigned W_CMD     = 2;
    localparam int unsigned W_STATUS  = 3;
    localparam int unsigned W_CAP     = 6;
    localparam int unsigned W_TIMER   = 8;
    localparam int unsigned W_USER    = 10;
    localparam int unsigned W_RECONF  = 12;

    localparam int unsigned GLB_W = 64;
    localparam int unsigned ACT_W = 32;

endpackage

// File: rtl/mmio_addr_split.sv
module mmio_addr_split #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ACT_OFF_W = 22,
    localparam int unsigned PASID_W  = ADDR_W - 1 - ACT_OFF_W,
    localparam int unsigned GIDX_W   = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 is_act,
    output logic [PASID_W-1:0]   pasid,
    output logic [ACT_OFF_W-1:0] act_off,
    output logic [GIDX_W-1:0]    glb_idx,
    output logic                 glb_aligned
);
    always_comb begin
        is_act      = addr[ADDR_W-1];
        pasid       = addr[ADDR_W-2 -: PASID_W];
        act_off     = addr[ACT_OFF_W-1:0];
        glb_idx     = addr[ADDR_W-2:3];
        glb_aligned = (addr[2:0] == 3'b000);
    end
endmodule

// File: rtl/mmio_glb_regs.sv
module mmio_glb_regs
    import mmio_dec_pkg::*;
#(
    parameter int unsigned GIDX_W      = 28,
    parameter int unsigned FAULT_W     = 8,
    parameter logic [63:0] VERSION     = 64'h0,
    parameter logic [63:0] BUILD_DATE  = 64'h0,
    parameter logic [63:0] CAPABILITY  = 64'h0,
    parameter logic [63:0] USER_CODE   = 64'h0,
    parameter logic [63:0] RECONF_CODE = 64'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [GIDX_W-1:0]  idx,
    input  logic               aligned,
    input  logic               wbit0,
    input  logic [FAULT_W-1:0] fault_bits,
    input  logic               axi_busy,
    input  logic               tlx_busy,
    input  logic               buf_empty,
    output logic [GLB_W-1:0]   rdata_q,
    output logic               soft_rst
);
    logic [GLB_W-1:0] uptime_q;
    logic [GLB_W-1:0] rd_mux;
    logic [GLB_W-1:0] status_word;
    logic             cmd_hit;

    assign status_word = {{(GLB_W-4){1'b0}}, |fault_bits, axi_busy, tlx_busy, buf_empty};
    assign cmd_hit     = wr_en && aligned && (idx == GIDX_W'(W_CMD)) && wbit0;

    always_comb begin
        unique case (idx)
            GIDX_W'(W_VERSION): rd_mux = VERSION;
            GIDX_W'(W_BUILD):   rd_mux = BUILD_DATE;
            GIDX_W'(W_STATUS):  rd_mux = status_word;
            GIDX_W'(W_CAP):     rd_mux = CAPABILITY;
            GIDX_W'(W_TIMER):   rd_mux = uptime_q;
            GIDX_W'(W_USER):    rd_mux = USER_CODE;
            GIDX_W'(W_RECONF):  rd_mux = RECONF_CODE;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uptime_q <= '0;
            rdata_q  <= '0;
            soft_rst <= 1'b0;
        end else begin
            uptime_q <= uptime_q + 1'b1;
            rdata_q  <= (rd_en && aligned) ? rd_mux : '0;
            soft_rst <= cmd_hit;
        end
    end
endmodule

// File: rtl/mmio_rsp_fsm.sv
module mmio_rsp_fsm
    import mmio_dec_pkg::*;
#(
    parameter int unsigned PASID_W   = 9,
    parameter int unsigned ACT_OFF_W = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 is_act,
    input  logic [PASID_W-1:0]   pasid,
    input  logic [ACT_OFF_W-1:0] act_off,
    input  logic [ACT_W-1:0]     wdata,
    input  logic [GLB_W-1:0]     glb_rdata,
    input  logic [ACT_W-1:0]     act_rdata,
    output logic                 rsp_valid,
    output logic [GLB_W-1:0]     rsp_rdata,
    output logic                 act_valid,
    output logic                 act_write,
    output logic [PASID_W-1:0]   act_pasid,
    output logic [ACT_OFF_W-1:0] act_offset,
    output logic [ACT_W-1:0]     act_wdata
);
    rsp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GLB_RSP, ST_ACT_RSP: begin
                if (!req_valid)  state_d = ST_IDLE;
                else if (is_act) state_d = ST_ACT_RSP;
                else             state_d = ST_GLB_RSP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            act_write  <= 1'b0;
            act_pasid  <= '0;
            act_offset <= '0;
            act_wdata  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && is_act) begin
                act_write  <= req_write;
                act_pasid  <= pasid;
                act_offset <= act_off;
                act_wdata  <= wdata;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        act_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GLB_RSP: begin
                rsp_valid = 1'b1;
                rsp_rdata = glb_rdata;
            end
            ST_ACT_RSP: begin
                rsp_valid = 1'b1;
                act_valid = 1'b1;
                rsp_rdata = act_write ? '0 : {{(GLB_W-ACT_W){1'b0}}, act_rdata};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmio_space_decoder.sv
module mmio_space_decoder
    import mmio_dec_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ACT_OFF_W   = 22,
    parameter int unsigned FAULT_W     = 8,
    parameter logic [63:0] VERSION     = 64'h0103_0402_1234_ABCD,
    parameter logic [63:0] BUILD_DATE  = 64'h0000_2024_0315_0930,
    parameter logic [63:0] CAPABILITY  = 64'h0000_0000_2000_0033,
    parameter logic [63:0] USER_CODE   = 64'h4445_4255_475F_3031,
    parameter logic [63:0] RECONF_CODE = 64'h5A3C_96E1_0F7B_C248,
    localparam int unsigned PASID_W    = ADDR_W - 1 - ACT_OFF_W,
    localparam int unsigned GIDX_W     = ADDR_W - 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [GLB_W-1:0]     req_wdata,
    output logic                 rsp_valid,
    output logic [GLB_W-1:0]     rsp_rdata,
    output logic                 act_valid,
    output logic                 act_write,
    output logic [PASID_W-1:0]   act_pasid,
    output logic [ACT_OFF_W-1:0] act_offset,
    output logic [ACT_W-1:0]     act_wdata,
    input  logic [ACT_W-1:0]     act_rdata,
    input  logic [FAULT_W-1:0]   fault_bits,
    input  logic                 axi_busy,
    input  logic                 tlx_busy,
    input  logic                 buf_empty,
    output logic                 soft_rst
);
    logic                 dec_is_act;
    logic [PASID_W-1:0]   dec_pasid;
    logic [ACT_OFF_W-1:0] dec_off;
    logic [GIDX_W-1:0]    dec_idx;
    logic                 dec_aligned;
    logic [GLB_W-1:0]     glb_rdata;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[GLB_W-1:ACT_W];

    mmio_addr_split #(.ADDR_W(ADDR_W), .ACT_OFF_W(ACT_OFF_W)) u_split (
        .addr        (req_addr),
        .is_act      (dec_is_act),
        .pasid       (dec_pasid),
        .act_off     (dec_off),
        .glb_idx     (dec_idx),
        .glb_aligned (dec_aligned)
    );

    mmio_glb_regs #(
        .GIDX_W(GIDX_W), .FAULT_W(FAULT_W), .VERSION(VERSION), .BUILD_DATE(BUILD_DATE),
        .CAPABILITY(CAPABILITY), .USER_CODE(USER_CODE), .RECONF_CODE(RECONF_CODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (req_valid && !req_write && !dec_is_act),
        .wr_en      (req_valid && req_write && !dec_is_act),
        .idx        (dec_idx),
        .aligned    (dec_aligned),
        .wbit0      (req_wdata[0]),
        .fault_bits (fault_bits),
        .axi_busy   (axi_busy),
        .tlx_busy   (tlx_busy),
        .buf_empty  (buf_empty),
        .rdata_q    (glb_rdata),
        .soft_rst   (soft_rst)
    );

    mmio_rsp_fsm #(.PASID_W(PASID_W), .ACT_OFF_W(ACT_OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .is_act     (dec_is_act),
        .pasid      (dec_pasid),
        .act_off    (dec_off),
        .wdata      (req_wdata[ACT_W-1:0]),
        .glb_rdata  (glb_rdata),
        .act_rdata  (act_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .act_valid  (act_valid),
        .act_write  (act_write),
        .act_pasid  (act_pasid),
        .act_offset (act_offset),
        .act_wdata  (act_wdata)
    );
endmodule

// File: rtl/mmio_space_decoder_chk.sv
module mmio_space_decoder_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ACT_OFF_W = 22,
    localparam int unsigned PASID_W  = ADDR_W - 1 - ACT_OFF_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [63:0]          req_wdata,
    input logic                 rsp_valid,
    input logic [63:0]          rsp_rdata,
    input logic                 act_valid,
    input logic                 act_write,
    input logic [PASID_W-1:0]   act_pasid,
    input logic [31:0]          act_rdata,
    input logic                 soft_rst
);
    logic cmd_fire;
    assign cmd_fire = req_valid && req_write && (req_addr == ADDR_W'(32'h10)) && req_wdata[0];

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
    AST_ACT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1]) |=> (act_valid && act_pasid == $past(req_addr[ADDR_W-2 -: PASID_W]))); // R1
    AST_GLB_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[ADDR_W-1]) |=> !act_valid); // R3
    AST_ACT_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !act_write) |-> (rsp_rdata == {32'h0, act_rdata})); // R3
    AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(cmd_fire)); // R5
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !cmd_fire) |=> !soft_rst); // R5
endmodule

bind mmio_space_decoder mmio_space_decoder_chk #(.ADDR_W(ADDR_W), .ACT_OFF_W(ACT_OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .act_valid (act_valid),
    .act_write (act_write),
    .act_pasid (act_pasid),
    .act_rdata (act_rdata),
    .soft_rst  (soft_rst)
);

// File: tb/mmio_space_decoder_tb.sv
module mmio_space_decoder_tb;
    localparam logic [63:0] P_VER = 64'h0A0B_0C0D_1122_3344;
    localparam logic [63:0] P_BLD = 64'h0000_2023_1107_1645;
    localparam logic [63:0] P_CAP = 64'h0000_0000_1000_0031;
    localparam logic [63:0] P_USR = 64'h5553_4552_5F43_4F44;
    localparam logic [63:0] P_RCF = 64'h0F1E_2D3C_4B5A_6978;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, act_valid, act_write, soft_rst;
    logic [63:0] rsp_rdata;
    logic [8:0]  act_pasid;
    logic [21:0] act_offset;
    logic [31:0] act_wdata, act_rdata;
    logic [7:0]  fault_bits = '0;
    logic        axi_busy = 1'b0, tlx_busy = 1'b0, buf_empty = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // bench model of the action registers
    assign act_rdata = {act_pasid, 1'b1, act_offset};

    mmio_space_decoder #(.VERSION(P_VER), .BUILD_DATE(P_BLD), .CAPABILITY(P_CAP),
        .USER_CODE(P_USR), .RECONF_CODE(P_RCF)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .act_valid(act_valid), .act_write(act_write),
        .act_pasid(act_pasid), .act_offset(act_offset), .act_wdata(act_wdata),
        .act_rdata(act_rdata), .fault_bits(fault_bits), .axi_busy(axi_busy),
        .tlx_busy(tlx_busy), .buf_empty(buf_empty), .soft_rst(soft_rst));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_glb(input logic [31:0] a);
        logic [63:0] st;
        st = {60'h0, |fault_bits, axi_busy, tlx_busy, buf_empty};
        if (a[2:0] != 3'b0) return 64'h0;
        case (a)
            32'h00: return P_VER;
            32'h08: return P_BLD;
            32'h18: return st;
            32'h30: return P_CAP;
            32'h50: return P_USR;
            32'h60: return P_RCF;
            default: return 64'h0;
        endcase
    endfunction

    task automatic do_req(input bit w, input logic [31:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [63:0] t0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!rsp_valid && !act_valid && !soft_rst, "R9 reset",
            {61'h0, rsp_valid, act_valid, soft_rst}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R2 idle after reset", {63'h0, rsp_valid}, 64'h0);

        // R4/R5/R8: read sweep over global offsets incl. misaligned
        for (int a = 0; a < 32'h200; a += 4) begin
            if (a == 32'h40) continue;
            do_req(1'b0, 32'(a), 64'h0);
            chk(rsp_valid && !act_valid && !soft_rst, "R2 R3 global read response",
                {62'h0, rsp_valid, act_valid}, 64'h2);
            chk(rsp_rdata == exp_glb(32'(a)), "R4 R8 global read data", rsp_rdata, exp_glb(32'(a)));
        end

        // R6: status sweep
        for (int i = 0; i < 32; i++) begin
            {axi_busy, tlx_busy, buf_empty} = 3'(i);
            fault_bits = (i[4:3] == 2'b0) ? 8'h0 : (8'h1 << ((i * 3) % 8));
            do_req(1'b0, 32'h18, 64'h0);
            chk(rsp_rdata == {60'h0, |fault_bits, axi_busy, tlx_busy, buf_empty}, "R6 status",
                rsp_rdata, {60'h0, |fault_bits, axi_busy, tlx_busy, buf_empty});
        end

        // R7: timer spacing
        for (int k = 0; k < 6; k++) begin
            do_req(1'b0, 32'h40, 64'h0);
            t0 = rsp_rdata;
            repeat (k) @(negedge clk);
            do_req(1'b0, 32'h40, 64'h0);
            chk(rsp_rdata - t0 == 64'(k + 2), "R7 timer delta", rsp_rdata - t0, 64'(k + 2));
        end

        // R5: command pulse and no pulse
        do_req(1'b1, 32'h10, 64'h1);
        chk(soft_rst && rsp_valid && rsp_rdata == 64'h0, "R5 pulse high", {63'h0, soft_rst}, 64'h1);
        @(negedge clk);
        chk(!soft_rst, "R5 pulse one cycle", {63'h0, soft_rst}, 64'h0);
        do_req(1'b1, 32'h10, 64'hFFFF_FFFF_FFFF_FFFE);
        chk(!soft_rst, "R5 bit0 clear no pulse", {63'h0, soft_rst}, 64'h0);

        // R8: writes elsewhere ignored
        for (int a = 0; a < 32'h100; a += 4) begin
            if (a == 32'h10) continue;
            do_req(1'b1, 32'(a), 64'hFFFF_FFFF_FFFF_FFFF);
            chk(!soft_rst && !act_valid && rsp_valid && rsp_rdata == 64'h0, "R8 write ignored",
                {61'h0, soft_rst, act_valid, rsp_valid}, 64'h1);
        end
        for (int a = 0; a < 32'h68; a += 8) begin
            if (a == 32'h40) continue;
            do_req(1'b0, 32'(a), 64'h0);
            chk(rsp_rdata == exp_glb(32'(a)), "R8 reread after writes", rsp_rdata, exp_glb(32'(a)));
        end

        // R1/R3: action sweep over process IDs
        for (int p = 0; p < 512; p += 17) begin
            for (int w = 0; w < 2; w++) begin
                logic [21:0] off;
                logic [63:0] d;
                off = 22'((p * 4 + w * 22'h3FFF00) & 22'h3FFFFC);
                d = {32'hDEAD_0000, 23'(p), 9'(w)};
                do_req(w[0], {1'b1, 9'(p), off}, d);
                chk(act_valid && act_pasid == 9'(p) && act_offset == off, "R1 tag and offset",
                    {act_pasid, act_offset}, {9'(p), off});
                chk(act_write == w[0] && act_wdata == d[31:0] && rsp_valid, "R3 forward",
                    {31'h0, act_write, act_wdata}, {31'h0, w[0], d[31:0]});
                chk(rsp_rdata == (w[0] ? 64'h0 : {32'h0, 9'(p), 1'b1, off}), "R3 response data",
                    rsp_rdata, (w[0] ? 64'h0 : {32'h0, 9'(p), 1'b1, off}));
            end
        end
        do_req(1'b0, 32'hFFFF_FFFC, 64'h0);
        chk(act_pasid == 9'h1FF && act_offset == 22'h3FFFFC, "R1 top process",
            {act_pasid, act_offset}, {9'h1FF, 22'h3FFFFC});

        // same-cycle case: command write then action read back-to-back
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h10; req_wdata = 64'h1;
        @(negedge clk);
        req_write = 1'b0; req_addr = {1'b1, 9'd5, 22'h40};
        chk(soft_rst && rsp_valid && !act_valid, "R5 pulse beside forward",
            {62'h0, soft_rst, act_valid}, 64'h2);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!soft_rst && act_valid && act_pasid == 9'd5 && rsp_rdata == {32'h0, 9'd5, 1'b1, 22'h40},
            "R3 forward after pulse", rsp_rdata, {32'h0, 9'd5, 1'b1, 22'h40});
        @(negedge clk);
        chk(!rsp_valid && !act_valid, "R2 quiet after chain", {62'h0, rsp_valid, act_valid}, 64'h0);

        done = 1'b1;
        finish_run();
    end
endmodule